// File: doc/BRIEF.md
# USB Endpoint Interrupt Aggregator

This block gathers per-endpoint completion events from a USB device core and turns them into one low-priority interrupt request for the processor. Each endpoint has a sticky status bit, an enable bit and a priority bit. Every status bit that is set and marked fast feeds a single fast summary bit. Every status bit that is set and marked slow feeds a single slow summary bit. A frame bit set by a free-running 1 ms tick covers isochronous endpoints, which raise no per-packet events. A separate system-error status vector has its own write-one-to-set and write-one-to-clear addresses.

Software reaches all registers over a small synchronous register bus. A write happens on the clock edge where `bus_wr` is high. Reads are combinational from the word index on `bus_addr`. Word indices: 0 endpoint status (read), 1 endpoint clear (W1C), 2 endpoint enable, 3 endpoint priority (1 = fast), 4 device status (read), 5 device clear (W1C), 6 device enable, 7 error status (read), 8 error set (W1S), 9 error clear (W1C), 10 mode. Device status bits are: bit 0 frame, bit 1 fast, bit 2 slow, bit 3 any system error.

Top module: `usb_ep_irq_agg`

## Requirements
- R1: After reset every readable register reads 0 and `irq_lp` is 0.
- R2: A qualified event on endpoint n sets bit n of endpoint status (word 0) only when bit n of endpoint enable (word 2) is 1.
- R3: A pulse on `ep_pkt_ok[n]` is a qualified event for every endpoint not set in `ISO_MASK`. Endpoints in `ISO_MASK` never set a status bit. Even indices are OUT endpoints and odd indices are IN endpoints.
- R4: A pulse on `ep_nak[n]` is a qualified event only for IN (odd) non-isochronous endpoints, and only while mode bit 0 (word 10) is 1. On all other endpoints it has no effect.
- R5: Device status bit 1 is the OR of the endpoint status bits whose priority bit is 1. Device status bit 2 is the OR of those whose priority bit is 0. Both follow the status bits in the same cycle.
- R6: Writing 1s to word 1 clears the matching endpoint status bits, and 0s have no effect. If an event sets a bit in the same cycle as a clear, the bit stays set.
- R7: Device status bit 0 is set `TICK_CYCLES` clocks after reset release and again every `TICK_CYCLES` clocks. Writing 1 to bit 0 of word 5 clears it.
- R8: Writing 1s to word 8 sets, and to word 9 clears, the matching error status bits (word 7), and 0s change nothing. Bits below `ERR_LO` always read 0. Device status bit 3 is the OR of the error status.
- R9: `irq_lp` is 1 exactly when some device status bit and its device enable bit (word 6) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| ep_pkt_ok | input | NUM_EP | Per-endpoint packet-done-without-error pulse |
| ep_nak | input | NUM_EP | Per-endpoint NAK-sent pulse |
| irq_lp | output | 1 | Low-priority interrupt request |

## Verification
The hardest case to reach from the ports is an endpoint event that lands in the same cycle as a software clear of that same status bit. Only that case decides whether an event can be lost. The bench holds a clear write and a packet pulse on the same falling edge, so both meet the same rising edge. One cleared bit also receives an event and another does not, which shows both outcomes in a single read. The frame period is also timed exactly, by counting clocks from reset release to the first and second setting of the frame bit.

// File: rtl/uep_pkg.sv
package uep_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DEV_W  = 4;

  localparam logic [ADDR_W-1:0] A_EP_STAT  = 4'd0;
  localparam logic [ADDR_W-1:0] A_EP_CLR   = 4'd1;
  localparam logic [ADDR_W-1:0] A_EP_EN    = 4'd2;
  localparam logic [ADDR_W-1:0] A_EP_PRIO  = 4'd3;
  localparam logic [ADDR_W-1:0] A_DEV_STAT = 4'd4;
  localparam logic [ADDR_W-1:0] A_DEV_CLR  = 4'd5;
  localparam logic [ADDR_W-1:0] A_DEV_EN   = 4'd6;
  localparam logic [ADDR_W-1:0] A_ERR_STAT = 4'd7;
  localparam logic [ADDR_W-1:0] A_ERR_SET  = 4'd8;
  localparam logic [ADDR_W-1:0] A_ERR_CLR  = 4'd9;
  localparam logic [ADDR_W-1:0] A_MODE     = 4'd10;

  localparam int unsigned DV_FRAME = 0;
  localparam int unsigned DV_FAST  = 1;
  localparam int unsigned DV_SLOW  = 2;
  localparam int unsigned DV_SERR  = 3;

  // decides whether a raw endpoint pulse counts as an interrupt event
  function automatic logic qualify_evt(input logic is_iso, input logic is_in,
                                       input logic pkt, input logic nak,
                                       input logic nak_mode);
    logic nak_hit;
    nak_hit = is_in & nak_mode & nak;
    return ~is_iso & (pkt | nak_hit);
  endfunction

  // OR of the status bits picked out by a selection mask
  function automatic logic group_any(input logic [DATA_W-1:0] st,
                                     input logic [DATA_W-1:0] sel);
    return |(st & sel);
  endfunction
endpackage

// File: rtl/uep_frame_timer.sv
module uep_frame_timer #(
  parameter int unsigned TICK_CYCLES = 48000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = $clog2(TICK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uep_ep_status.sv
module uep_ep_status
  import uep_pkg::*;
#(
  parameter int unsigned NUM_EP   = 32,
  parameter logic [31:0] ISO_MASK = 32'h0000_0030
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] pkt_ok,
  input  logic [NUM_EP-1:0] nak,
  input  logic              nak_mode,
  input  logic [NUM_EP-1:0] ep_en,
  input  logic              clr_wr,
  input  logic [NUM_EP-1:0] clr_mask,
  output logic [NUM_EP-1:0] set_evt,
  output logic [NUM_EP-1:0] status
);
  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    localparam logic IS_ISO = ISO_MASK[i];
    localparam logic IS_IN  = ((i % 2) == 1);

    assign set_evt[i] = ep_en[i] & qualify_evt(IS_ISO, IS_IN, pkt_ok[i], nak[i], nak_mode);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      status[i] <= 1'b0;
      else if (set_evt[i])             status[i] <= 1'b1;
      else if (clr_wr && clr_mask[i])  status[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/uep_err_regs.sv
module uep_err_regs #(
  parameter int unsigned NUM_EP = 32,
  parameter int unsigned ERR_LO = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wr,
  input  logic              clr_wr,
  input  logic [NUM_EP-1:0] wmask,
  output logic [NUM_EP-1:0] status
);
  for (genvar i = 0; i < NUM_EP; i++) begin : g_bit
    if (i < ERR_LO) begin : g_none
      assign status[i] = 1'b0;
    end else begin : g_reg
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  bit_q <= 1'b0;
        else if (set_wr && wmask[i]) bit_q <= 1'b1;
        else if (clr_wr && wmask[i]) bit_q <= 1'b0;
      end
      assign status[i] = bit_q;
    end
  end
endmodule

// File: rtl/usb_ep_irq_agg.sv
module usb_ep_irq_agg
  import uep_pkg::*;
#(
  parameter int unsigned NUM_EP      = 32,
  parameter logic [31:0] ISO_MASK    = 32'h0000_0030,
  parameter int unsigned TICK_CYCLES = 48000,
  parameter int unsigned ERR_LO      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_EP-1:0] ep_pkt_ok,
  input  logic [NUM_EP-1:0] ep_nak,
  output logic              irq_lp
);
  logic [NUM_EP-1:0] ep_en_q, ep_prio_q, ep_st, ep_set_evt, err_st;
  logic [DEV_W-1:0]  dev_en_q, dev_st;
  logic              nak_mode_q, frame_q, frame_tick;
  logic              wr_ep_clr, wr_dev_clr, wr_err_set, wr_err_clr, err_wr_any;
  logic [NUM_EP-1:0] wmask;

  assign wmask      = bus_wdata[NUM_EP-1:0];
  assign wr_ep_clr  = bus_wr && (bus_addr == A_EP_CLR);
  assign wr_dev_clr = bus_wr && (bus_addr == A_DEV_CLR);
  assign wr_err_set = bus_wr && (bus_addr == A_ERR_SET);
  assign wr_err_clr = bus_wr && (bus_addr == A_ERR_CLR);
  assign err_wr_any = wr_err_set | wr_err_clr;

  uep_frame_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick)
  );

  uep_ep_status #(.NUM_EP(NUM_EP), .ISO_MASK(ISO_MASK)) u_ep (
    .clk(clk), .rst_n(rst_n), .pkt_ok(ep_pkt_ok), .nak(ep_nak),
    .nak_mode(nak_mode_q), .ep_en(ep_en_q), .clr_wr(wr_ep_clr),
    .clr_mask(wmask), .set_evt(ep_set_evt), .status(ep_st)
  );

  uep_err_regs #(.NUM_EP(NUM_EP), .ERR_LO(ERR_LO)) u_err (
    .clk(clk), .rst_n(rst_n), .set_wr(wr_err_set), .clr_wr(wr_err_clr),
    .wmask(wmask), .status(err_st)
  );

  // software-owned configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep_en_q    <= '0;
      ep_prio_q  <= '0;
      dev_en_q   <= '0;
      nak_mode_q <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_EP_EN:   ep_en_q    <= wmask;
        A_EP_PRIO: ep_prio_q  <= wmask;
        A_DEV_EN:  dev_en_q   <= bus_wdata[DEV_W-1:0];
        A_MODE:    nak_mode_q <= bus_wdata[0];
        default:   ;
      endcase
    end
  end

  // sticky frame bit, tick wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          frame_q <= 1'b0;
    else if (frame_tick)                 frame_q <= 1'b1;
    else if (wr_dev_clr && bus_wdata[0]) frame_q <= 1'b0;
  end

  logic [31:0] st_w, prio_w, err_w;
  assign st_w   = 32'(ep_st);
  assign prio_w = 32'(ep_prio_q);
  assign err_w  = 32'(err_st);

  always_comb begin
    dev_st           = '0;
    dev_st[DV_FRAME] = frame_q;
    dev_st[DV_FAST]  = group_any(st_w, prio_w);
    dev_st[DV_SLOW]  = group_any(st_w, ~prio_w);
    dev_st[DV_SERR]  = |err_st;
  end

  assign irq_lp = |(dev_st & dev_en_q);

  always_comb begin
    case (bus_addr)
      A_EP_STAT:  bus_rdata = st_w;
      A_EP_EN:    bus_rdata = 32'(ep_en_q);
      A_EP_PRIO:  bus_rdata = prio_w;
      A_DEV_STAT: bus_rdata = 32'(dev_st);
      A_DEV_EN:   bus_rdata = 32'(dev_en_q);
      A_ERR_STAT: bus_rdata = err_w;
      A_MODE:     bus_rdata = 32'(nak_mode_q);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uep_irq_checker.sv
module uep_irq_checker #(
  parameter int unsigned NUM_EP = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_EP-1:0] ep_st,
  input logic [NUM_EP-1:0] ep_en,
  input logic [NUM_EP-1:0] ep_set_evt,
  input logic [NUM_EP-1:0] ep_prio,
  input logic [3:0]        dev_st,
  input logic [3:0]        dev_en,
  input logic              irq_lp,
  input logic              frame_tick,
  input logic [NUM_EP-1:0] err_st,
  input logic              err_wr
);
  a_r2_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_st != '1) |=> ((ep_st & ~$past(ep_st) & ~$past(ep_en)) == '0));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_set_evt != '0) |=> (($past(ep_set_evt) & ~ep_st) == '0));

  a_r5_fast_group: assert property (@(posedge clk) disable iff (!rst_n)
    dev_st[1] == ((ep_st & ep_prio) != '0));

  a_r5_slow_group: assert property (@(posedge clk) disable iff (!rst_n)
    dev_st[2] == ((ep_st & ~ep_prio) != '0));

  a_r7_frame_set: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> dev_st[0]);

  a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !err_wr |=> $stable(err_st));

  a_r8_err_summary: assert property (@(posedge clk) disable iff (!rst_n)
    dev_st[3] == (err_st != '0));

  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lp == ((dev_st & dev_en) != '0));
endmodule

bind usb_ep_irq_agg uep_irq_checker #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ep_st(ep_st), .ep_en(ep_en_q),
  .ep_set_evt(ep_set_evt), .ep_prio(ep_prio_q), .dev_st(dev_st),
  .dev_en(dev_en_q), .irq_lp(irq_lp), .frame_tick(frame_tick),
  .err_st(err_st), .err_wr(err_wr_any)
);

// File: tb/usb_ep_irq_agg_tb.sv
module usb_ep_irq_agg_tb;
  localparam int unsigned TICK = 200;
  localparam logic [31:0] ISO  = 32'h0000_0030;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] ep_pkt_ok = '0;
  logic [31:0] ep_nak = '0;
  logic        irq_lp;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  usb_ep_irq_agg #(.NUM_EP(32), .ISO_MASK(ISO), .TICK_CYCLES(TICK), .ERR_LO(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ep_pkt_ok(ep_pkt_ok),
    .ep_nak(ep_nak), .irq_lp(irq_lp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] pkt, input logic [31:0] nak);
    @(negedge clk);
    ep_pkt_ok = pkt; ep_nak = nak;
    @(negedge clk);
    ep_pkt_ok = '0; ep_nak = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reg %0d", a), v, 32'h0);
    end
    chk("R1 irq_lp", {31'h0, irq_lp}, 32'h0);
  endtask

  task automatic t_frame;
    logic [31:0] v;
    int first_at, second_at;
    v = '0;
    while (v[0] == 1'b0) rd(4'd4, v);
    first_at = cyc;
    chk("R7 first frame cycle", first_at, TICK);
    wr(4'd5, 32'h1);
    rd(4'd4, v);
    chk("R7 frame cleared", v & 32'h1, 32'h0);
    while (v[0] == 1'b0) rd(4'd4, v);
    second_at = cyc;
    chk("R7 second frame cycle", second_at, 2 * TICK);
    wr(4'd5, 32'h1);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr(4'd2, 32'h0000_0003);
    pulse(32'h0000_0F0F, '0);
    rd(4'd0, v);
    chk("R2 enable gate", v, 32'h0000_0003);
    wr(4'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_iso;
    logic [31:0] v;
    wr(4'd2, 32'hFFFF_FFFF);
    pulse(32'hFFFF_FFFF, '0);
    rd(4'd0, v);
    chk("R3 iso endpoints never set", v, ~ISO);
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd0, v);
    chk("R6 clear all", v, 32'h0);
  endtask

  task automatic t_nak;
    logic [31:0] v;
    wr(4'd10, 32'h0);
    pulse('0, 32'hFFFF_FFFF);
    rd(4'd0, v);
    chk("R4 nak ignored with mode off", v, 32'h0);
    wr(4'd10, 32'h1);
    pulse('0, 32'hFFFF_FFFF);
    rd(4'd0, v);
    chk("R4 nak on odd non-iso only", v, 32'hAAAA_AA8A);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd10, 32'h0);
  endtask

  task automatic t_prio;
    logic [31:0] v;
    wr(4'd3, 32'h0000_0100);
    pulse(32'h0000_0100, '0);
    rd(4'd4, v);
    chk("R5 fast only", v & 32'h6, 32'h2);
    wr(4'd1, 32'hFFFF_FFFF);
    pulse(32'h0000_0200, '0);
    rd(4'd4, v);
    chk("R5 slow only", v & 32'h6, 32'h4);
    pulse(32'h0000_0100, '0);
    rd(4'd4, v);
    chk("R5 fast and slow", v & 32'h6, 32'h6);
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd4, v);
    chk("R5 groups drop after clear", v & 32'h6, 32'h0);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    pulse(32'h0000_000F, '0);
    wr(4'd1, 32'h0000_0003);
    rd(4'd0, v);
    chk("R6 partial clear", v, 32'h0000_000C);
    // event on bit 2 meets a clear of bits 2 and 3 on the same edge
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 32'h0000_000C;
    ep_pkt_ok = 32'h0000_0004;
    @(negedge clk);
    bus_wr = 1'b0; ep_pkt_ok = '0;
    rd(4'd0, v);
    chk("R6 set wins over clear", v, 32'h0000_0004);
    wr(4'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_err;
    logic [31:0] v;
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd7, v);
    chk("R8 set all, low bits absent", v, 32'hFFFF_FFFC);
    rd(4'd4, v);
    chk("R8 summary bit set", v & 32'h8, 32'h8);
    wr(4'd9, 32'h0000_00F0);
    rd(4'd7, v);
    chk("R8 partial clear", v, 32'hFFFF_FF0C);
    wr(4'd8, 32'h0);
    rd(4'd7, v);
    chk("R8 zero write no effect", v, 32'hFFFF_FF0C);
    wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd7, v);
    chk("R8 clear all", v, 32'h0);
    rd(4'd4, v);
    chk("R8 summary bit cleared", v & 32'h8, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd6, 32'h2);
    @(negedge clk);
    chk("R9 idle irq low", {31'h0, irq_lp}, 32'h0);
    pulse(32'h0000_0001, '0);
    chk("R9 fast enabled irq", {31'h0, irq_lp}, 32'h1);
    wr(4'd6, 32'h4);
    chk("R9 fast masked irq", {31'h0, irq_lp}, 32'h0);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd6, 32'h8);
    wr(4'd8, 32'h0000_0080);
    chk("R9 error enabled irq", {31'h0, irq_lp}, 32'h1);
    wr(4'd9, 32'h0000_0080);
    chk("R9 error cleared irq", {31'h0, irq_lp}, 32'h0);
    rd(4'd6, v);
    chk("R9 enable readback", v, 32'h8);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 150000);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_frame();
    t_enable();
    t_iso();
    t_nak();
    t_prio();
    t_clear();
    t_err();
    t_irq();
    report();
  end
endmodule